// File: doc/BRIEF.md
# Hash Engine Register Front End

This block sits between a 32-bit register bus and a hash datapath. Software programs the source, digest and key buffer addresses, the message length, and then writes a command word. The block stores every register through a write mask, splits the command into an algorithm selection, a digest mode and a scatter-gather enable, and checks that the algorithm selection is a supported one.

A supported command produces a one-cycle start pulse toward the datapath. Its decoded fields stay steady until the datapath returns a done pulse. Completion is recorded in a status flag no matter how the interrupt enable is set. The interrupt line follows the flag only for commands that asked for it. An unsupported selection never starts the datapath. It raises an error pulse and completes at once, so software waiting on the flag is not left hanging. Software clears the flag by writing a one to it.

Top module: `hash_regfront`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `irq` is 0 and `hash_start` is 0.
- R2: The length register (word 0x0B) keeps only bits [27:0]. The digest address (word 0x09) has bits [2:0] forced to 0. The three high address words (0x24 source, 0x25 digest, 0x26 key) keep only bits [1:0]. The source (0x08), key (0x0A) and crypt command (0x04) words keep all 32 bits.
- R3: The hash command word (0x0C) reads back the written value ANDed with 0x00147FFF.
- R4: Command bits [6:4] choose the family: 000 MD5, 010 SHA-1, 100 SHA-224, 101 SHA-256, 110 SHA-512 family. For the first four, bits [12:10] must be 000. For the SHA-512 family, bits [12:10] give 000 SHA-512, 001 SHA-384, 010 SHA-512/256. `hash_algo` encodes these as 0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256, 4 SHA-512, 5 SHA-384, 6 SHA-512/256.
- R5: Any other selection gives no start. In the cycle after the write it gives a one-cycle `cmd_err` pulse, and the completion flag is set on the same edge.
- R6: A supported command write pulses `hash_start` for exactly the cycle after the write. `hash_algo`, `hash_mode` (command bits [8:7]) and `hash_sg` (command bit 18) hold that command's values until the next accepted command.
- R7: A `hash_done` pulse while a command is in flight sets status bit 9, with or without the interrupt enable. A `hash_done` with nothing in flight is ignored.
- R8: `irq` rises on completion only when command bit 9 of the completing command was 1.
- R9: A status write (word 0x07) with bit 9 set clears the flag and `irq`. A status write with bit 9 clear changes nothing. Status bits other than 9 read 0.
- R10: A command write while a command is in flight is ignored. The stored command is unchanged and no start pulse is produced.
- R11: If a completion and a clearing status write land on the same edge, the flag ends up set.
- R12: `src_addr`, `dig_addr` and `key_addr` present {high word bits [1:0], low word}. `src_len` presents the stored length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hash_start | output | 1 | One-cycle start pulse to the datapath |
| hash_algo | output | 3 | Decoded algorithm code |
| hash_mode | output | 2 | Digest mode field |
| hash_sg | output | 1 | Scatter-gather enable |
| hash_done | input | 1 | Completion pulse from the datapath |
| src_addr | output | 32+HI_W | Source address |
| dig_addr | output | 32+HI_W | Digest address |
| key_addr | output | 32+HI_W | Key buffer address |
| src_len | output | LEN_W | Source length |
| cmd_err | output | 1 | Pulse for an unsupported command |
| irq | output | 1 | Interrupt level |

## Verification
The assertions check several rules on every cycle. A start must follow a command write. A start is never two cycles long and never coincides with an error pulse. An error pulse always comes with the completion flag. The interrupt never stands without the flag. The flag rises only after a done pulse or a command write. A clearing write with no competing completion always drops the interrupt. Only the bench scenarios can show that the decoded algorithm codes and the readback masks match their values. The same holds for the interrupt-enable gating, the ignored command while busy, and set-over-clear priority.

// File: rtl/hrf_pkg.sv
`timescale 1ns/1ps
// Package: shared register word indices, command field positions and the
// algorithm code type of the hash register front end.
package hrf_pkg;
    localparam int unsigned OFF_CRYPT  = 4;
    localparam int unsigned OFF_STATUS = 7;
    localparam int unsigned OFF_SRC    = 8;
    localparam int unsigned OFF_DIG    = 9;
    localparam int unsigned OFF_KEY    = 10;
    localparam int unsigned OFF_LEN    = 11;
    localparam int unsigned OFF_HCMD   = 12;
    localparam int unsigned OFF_HI0    = 36;   // source, digest, key highs follow

    localparam logic [31:0] CMD_MASK  = 32'h0014_7FFF;
    localparam int unsigned IE_BIT    = 9;
    localparam int unsigned SG_BIT    = 18;
    localparam int unsigned DONE_BIT  = 9;

    typedef enum logic [2:0] {
        ALG_MD5     = 3'd0,
        ALG_SHA1    = 3'd1,
        ALG_SHA224  = 3'd2,
        ALG_SHA256  = 3'd3,
        ALG_SHA512  = 3'd4,
        ALG_SHA384  = 3'd5,
        ALG_S512_256 = 3'd6
    } hash_alg_e;
endpackage

// File: rtl/hrf_regbank.sv
`timescale 1ns/1ps
// Module: hrf_regbank
// Holds the address, length and crypt command words, applying the write
// masks. Assumes bus_addr is a word index. High address words exist only
// when DMA64 is set; otherwise they read and present zero.
module hrf_regbank
    import hrf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned LEN_W     = 28,
    parameter int unsigned HI_W      = 2,
    parameter int unsigned DIG_ALIGN = 3,
    parameter bit          DMA64     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31+HI_W:0]  src_addr,
    output logic [31+HI_W:0]  dig_addr,
    output logic [31+HI_W:0]  key_addr,
    output logic [LEN_W-1:0]  src_len,
    output logic [31:0]       rd_data
);
    localparam int unsigned NHI = 3;
    localparam logic [31:0] DIG_MASK = ~((32'd1 << DIG_ALIGN) - 32'd1);

    logic [31:0]      crypt_q, src_q, dig_q, key_q;
    logic [LEN_W-1:0] len_q;
    logic [HI_W-1:0]  hi_q [NHI];

    // Low words and length: masked capture on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crypt_q <= '0;
            src_q   <= '0;
            dig_q   <= '0;
            key_q   <= '0;
            len_q   <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(OFF_CRYPT)) crypt_q <= wdata;
            if (addr == ADDR_W'(OFF_SRC))   src_q   <= wdata;
            if (addr == ADDR_W'(OFF_DIG))   dig_q   <= wdata & DIG_MASK;
            if (addr == ADDR_W'(OFF_KEY))   key_q   <= wdata;
            if (addr == ADDR_W'(OFF_LEN))   len_q   <= wdata[LEN_W-1:0];
        end
    end

    for (genvar gi = 0; gi < NHI; gi++) begin : g_hi
        if (DMA64) begin : g_on
            // High address word: keep the low HI_W bits on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hi_q[gi] <= '0;
                else if (we && addr == ADDR_W'(OFF_HI0 + gi))
                    hi_q[gi] <= wdata[HI_W-1:0];
            end
        end else begin : g_off
            assign hi_q[gi] = '0;
        end
    end

    assign src_addr = {hi_q[0], src_q};
    assign dig_addr = {hi_q[1], dig_q};
    assign key_addr = {hi_q[2], key_q};
    assign src_len  = len_q;

    // Read mux for the words this bank owns; others read zero here.
    always_comb begin
        rd_data = '0;
        if      (addr == ADDR_W'(OFF_CRYPT))   rd_data = crypt_q;
        else if (addr == ADDR_W'(OFF_SRC))     rd_data = src_q;
        else if (addr == ADDR_W'(OFF_DIG))     rd_data = dig_q;
        else if (addr == ADDR_W'(OFF_KEY))     rd_data = key_q;
        else if (addr == ADDR_W'(OFF_LEN))     rd_data = 32'(len_q);
        else if (addr == ADDR_W'(OFF_HI0))     rd_data = 32'(hi_q[0]);
        else if (addr == ADDR_W'(OFF_HI0 + 1)) rd_data = 32'(hi_q[1]);
        else if (addr == ADDR_W'(OFF_HI0 + 2)) rd_data = 32'(hi_q[2]);
    end
endmodule

// File: rtl/hrf_cmd_decode.sv
`timescale 1ns/1ps
// Module: hrf_cmd_decode
// Combinational decode of an already-masked command word into the
// algorithm code, digest mode, scatter-gather and interrupt enable, plus a
// validity flag. Non-family codes require a zero sub-select field.
module hrf_cmd_decode
    import hrf_pkg::*;
(
    input  logic [31:0] cmd,
    output logic        valid,
    output hash_alg_e   algo,
    output logic [1:0]  mode,
    output logic        sg,
    output logic        ie
);
    logic [2:0] fam, sub;
    assign fam  = cmd[6:4];
    assign sub  = cmd[12:10];
    assign mode = cmd[8:7];
    assign sg   = cmd[SG_BIT];
    assign ie   = cmd[IE_BIT];

    // Two-level selection: family first, then sub-select for the wide family.
    always_comb begin
        valid = 1'b0;
        algo  = ALG_MD5;
        unique case (fam)
            3'b000: begin algo = ALG_MD5;    valid = (sub == 3'b000); end
            3'b010: begin algo = ALG_SHA1;   valid = (sub == 3'b000); end
            3'b100: begin algo = ALG_SHA224; valid = (sub == 3'b000); end
            3'b101: begin algo = ALG_SHA256; valid = (sub == 3'b000); end
            3'b110: begin
                unique case (sub)
                    3'b000:  begin algo = ALG_SHA512;   valid = 1'b1; end
                    3'b001:  begin algo = ALG_SHA384;   valid = 1'b1; end
                    3'b010:  begin algo = ALG_S512_256; valid = 1'b1; end
                    default: valid = 1'b0;
                endcase
            end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/hrf_ctrl.sv
`timescale 1ns/1ps
// Module: hrf_ctrl
// Command register, in-flight tracking, start pulse, completion flag with
// write-one-to-clear, and interrupt. Assumes hash_done is only meaningful
// while a command is in flight. Completion wins over a same-edge clear.
module hrf_ctrl
    import hrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        stat_wr,
    input  logic [31:0] wdata,
    input  logic        dec_valid,
    input  hash_alg_e   dec_algo,
    input  logic [1:0]  dec_mode,
    input  logic        dec_sg,
    input  logic        dec_ie,
    input  logic        hash_done,
    output logic [31:0] cmd_q,
    output logic        start,
    output hash_alg_e   algo_q,
    output logic [1:0]  mode_q,
    output logic        sg_q,
    output logic        done_flag,
    output logic        irq,
    output logic        cmd_err
);
    logic busy_q, ie_q;
    logic accept, launch, reject, finish, complete, raise, clear;

    assign accept   = cmd_wr && !busy_q;
    assign launch   = accept && dec_valid;
    assign reject   = accept && !dec_valid;
    assign finish   = busy_q && hash_done;
    assign complete = finish || reject;
    assign raise    = (finish && ie_q) || (reject && dec_ie);
    assign clear    = stat_wr && wdata[DONE_BIT];

    // Command storage and in-flight tracking with latched decoded fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            busy_q <= 1'b0;
            ie_q   <= 1'b0;
            algo_q <= ALG_MD5;
            mode_q <= '0;
            sg_q   <= 1'b0;
        end else begin
            if (accept) cmd_q <= wdata & CMD_MASK;
            if (launch) begin
                busy_q <= 1'b1;
                ie_q   <= dec_ie;
                algo_q <= dec_algo;
                mode_q <= dec_mode;
                sg_q   <= dec_sg;
            end else if (finish) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Single-cycle start and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start   <= 1'b0;
            cmd_err <= 1'b0;
        end else begin
            start   <= launch;
            cmd_err <= reject;
        end
    end

    // Completion flag and interrupt: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (complete)   done_flag <= 1'b1;
            else if (clear) done_flag <= 1'b0;
            if (raise)      irq <= 1'b1;
            else if (clear) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/hash_regfront.sv
`timescale 1ns/1ps
// Module: hash_regfront
// Top of the hash register front end: address bank, command decoder and
// control, with the combined read mux. Assumes single-cycle register writes
// and combinational reads on a word-indexed bus.
module hash_regfront
    import hrf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned LEN_W     = 28,
    parameter int unsigned HI_W      = 2,
    parameter int unsigned DIG_ALIGN = 3,
    parameter bit          DMA64     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              hash_start,
    output logic [2:0]        hash_algo,
    output logic [1:0]        hash_mode,
    output logic              hash_sg,
    input  logic              hash_done,
    output logic [31+HI_W:0]  src_addr,
    output logic [31+HI_W:0]  dig_addr,
    output logic [31+HI_W:0]  key_addr,
    output logic [LEN_W-1:0]  src_len,
    output logic              cmd_err,
    output logic              irq
);
    logic        cmd_wr, stat_wr;
    logic [31:0] bank_rd, cmd_q;
    logic        done_flag;
    logic        dec_valid, dec_sg, dec_ie;
    logic [1:0]  dec_mode;
    hash_alg_e   dec_algo, algo_q;

    assign cmd_wr  = bus_we && (bus_addr == ADDR_W'(OFF_HCMD));
    assign stat_wr = bus_we && (bus_addr == ADDR_W'(OFF_STATUS));

    hrf_regbank #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .HI_W(HI_W),
        .DIG_ALIGN(DIG_ALIGN), .DMA64(DMA64)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .src_addr(src_addr), .dig_addr(dig_addr),
        .key_addr(key_addr), .src_len(src_len), .rd_data(bank_rd)
    );

    hrf_cmd_decode u_dec (
        .cmd(bus_wdata & CMD_MASK), .valid(dec_valid), .algo(dec_algo),
        .mode(dec_mode), .sg(dec_sg), .ie(dec_ie)
    );

    hrf_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .stat_wr(stat_wr),
        .wdata(bus_wdata), .dec_valid(dec_valid), .dec_algo(dec_algo),
        .dec_mode(dec_mode), .dec_sg(dec_sg), .dec_ie(dec_ie),
        .hash_done(hash_done), .cmd_q(cmd_q), .start(hash_start),
        .algo_q(algo_q), .mode_q(hash_mode), .sg_q(hash_sg),
        .done_flag(done_flag), .irq(irq), .cmd_err(cmd_err)
    );

    assign hash_algo = algo_q;

    // Read mux: control-owned words first, then the bank.
    always_comb begin
        if (bus_addr == ADDR_W'(OFF_HCMD))
            bus_rdata = cmd_q;
        else if (bus_addr == ADDR_W'(OFF_STATUS))
            bus_rdata = 32'(done_flag) << DONE_BIT;
        else
            bus_rdata = bank_rd;
    end
endmodule

// File: rtl/hrf_checker.sv
`timescale 1ns/1ps
// Module: hrf_checker
// Temporal checks on the front end's pulses, flag and interrupt. Bound to
// every hash_regfront instance.
module hrf_checker
    import hrf_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              hash_done,
    input logic              hash_start,
    input logic              cmd_err,
    input logic              irq,
    input logic              done_flag
);
    logic cw, clr;
    assign cw  = bus_we && (bus_addr == ADDR_W'(OFF_HCMD));
    assign clr = bus_we && (bus_addr == ADDR_W'(OFF_STATUS)) && bus_wdata[DONE_BIT];

    a_r6_start_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |-> $past(cw));
    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |=> !hash_start);
    a_r5_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !hash_start);
    a_r5_err_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> done_flag);
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);
    a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(hash_done || cw));
    a_r9_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hash_done) |=> !irq);
endmodule

bind hash_regfront hrf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .hash_done(hash_done), .hash_start(hash_start),
    .cmd_err(cmd_err), .irq(irq), .done_flag(done_flag)
);

// File: tb/hash_regfront_tb.sv
`timescale 1ns/1ps
// Bench: seeded random commands mixed with directed corner cases, checked
// against expected values from bench functions.
module hash_regfront_tb;
    localparam int AW = 6;
    localparam logic [AW-1:0] A_CRYPT = 6'd4, A_STAT = 6'd7, A_SRC = 6'd8,
        A_DIG = 6'd9, A_KEY = 6'd10, A_LEN = 6'd11, A_CMD = 6'd12,
        A_SHI = 6'd36, A_DHI = 6'd37, A_KHI = 6'd38;

    logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, hash_done = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic hash_start, hash_sg, cmd_err, irq;
    logic [2:0] hash_algo;
    logic [1:0] hash_mode;
    logic [33:0] src_addr, dig_addr, key_addr;
    logic [27:0] src_len;
    int n_chk = 0, n_fail = 0;
    bit  ended = 0;

    always #2.5 clk = ~clk;

    hash_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hash_start(hash_start),
        .hash_algo(hash_algo), .hash_mode(hash_mode), .hash_sg(hash_sg),
        .hash_done(hash_done), .src_addr(src_addr), .dig_addr(dig_addr),
        .key_addr(key_addr), .src_len(src_len), .cmd_err(cmd_err), .irq(irq)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a; #0.5; d = bus_rdata;
    endtask

    task automatic done_pulse();
        @(negedge clk); hash_done = 1'b1;
        @(negedge clk); hash_done = 1'b0;
    endtask

    function automatic bit f_valid(logic [31:0] c);
        case (c[6:4])
            3'b000, 3'b010, 3'b100, 3'b101: return c[12:10] == 3'b000;
            3'b110: return c[12:10] <= 3'b010;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [2:0] f_algo(logic [31:0] c);
        case (c[6:4])
            3'b000: return 3'd0;
            3'b010: return 3'd1;
            3'b100: return 3'd2;
            3'b101: return 3'd3;
            default: return 3'd4 + c[12:10];
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, c, m;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(A_CMD, d);  check("R1 cmd", d, 0);
        rd(A_STAT, d); check("R1 status", d, 0);
        rd(A_LEN, d);  check("R1 len", d, 0);
        check("R1 irq", irq, 0);
        check("R1 start", hash_start, 0);
        // R7 done while idle ignored
        done_pulse(); rd(A_STAT, d); check("R7 idle done", d, 0);
        // R2 masks and R12 outputs
        wr(A_LEN, 32'hFFFF_FFFF); rd(A_LEN, d); check("R2 len", d, 32'h0FFF_FFFF);
        wr(A_DIG, 32'hFFFF_FFFF); rd(A_DIG, d); check("R2 dig", d, 32'hFFFF_FFF8);
        wr(A_SHI, 32'hFFFF_FFFF); rd(A_SHI, d); check("R2 src hi", d, 3);
        wr(A_DHI, 32'hFFFF_FFFE); rd(A_DHI, d); check("R2 dig hi", d, 2);
        wr(A_KHI, 32'h0000_0005); rd(A_KHI, d); check("R2 key hi", d, 1);
        wr(A_SRC, 32'h1234_5678); rd(A_SRC, d); check("R2 src", d, 32'h1234_5678);
        wr(A_KEY, 32'hCAFE_F00F); rd(A_KEY, d); check("R2 key", d, 32'hCAFE_F00F);
        wr(A_CRYPT, 32'hA5A5_5A5A); rd(A_CRYPT, d); check("R2 crypt", d, 32'hA5A5_5A5A);
        check("R12 src_addr", src_addr, {2'b11, 32'h1234_5678});
        check("R12 dig_addr", dig_addr, {2'b10, 32'hFFFF_FFF8});
        check("R12 key_addr", key_addr, {2'b01, 32'hCAFE_F00F});
        check("R12 src_len", src_len, 28'hFFF_FFFF);
        // R10 command while busy ignored
        wr(A_CMD, 32'h0000_0020); check("R6 start sha1", hash_start, 1);
        wr(A_CMD, 32'h0000_0250); check("R10 no start", hash_start, 0);
        rd(A_CMD, d); check("R10 cmd kept", d, 32'h20);
        done_pulse(); rd(A_STAT, d); check("R7 flag no ie", d, 32'h200);
        check("R8 irq off", irq, 0);
        // R9 write with bit 9 clear has no effect
        wr(A_STAT, 32'hFFFF_FDFF); rd(A_STAT, d); check("R9 no clear", d, 32'h200);
        wr(A_STAT, 32'h0000_0200); rd(A_STAT, d); check("R9 clear", d, 0);
        // R11 completion and clear together
        wr(A_CMD, 32'h0000_0050);
        @(negedge clk); bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h200; hash_done = 1'b1;
        @(negedge clk); bus_we = 1'b0; hash_done = 1'b0;
        rd(A_STAT, d); check("R11 set wins", d, 32'h200);
        wr(A_STAT, 32'h200);
        // Random commands covering R3..R9
        for (int i = 0; i < 60; i++) begin
            c = $urandom;
            c[6:4] = 3'($urandom % 8);
            if ($urandom % 3 != 0) c[12:10] = (c[6:4] == 3'b110) ? 3'($urandom % 4) : 3'b000;
            m = c & 32'h0014_7FFF;
            wr(A_CMD, c);
            check("R6 start", hash_start, f_valid(m));
            check("R5 err", cmd_err, !f_valid(m));
            rd(A_CMD, d); check("R3 cmd mask", d, m);
            if (f_valid(m)) begin
                check("R4 algo", hash_algo, f_algo(m));
                check("R6 mode", hash_mode, m[8:7]);
                check("R6 sg", hash_sg, m[18]);
                repeat ($urandom % 3) @(negedge clk);
                rd(A_STAT, d); check("R7 not yet", d, 0);
                done_pulse();
            end
            rd(A_STAT, d); check("R7 flag", d, 32'h200);
            check("R8 irq", irq, m[9]);
            wr(A_STAT, 32'h200);
            check("R9 irq cleared", irq, 0);
            rd(A_STAT, d); check("R9 flag cleared", d, 0);
        end
        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule